// File: doc/BRIEF.md
# Kernel-Only Loop Pipeline Controller

This block sequences a software-pipelined loop that runs only its steady-state body. The prologue and epilogue are formed by masking whole pipeline stages. Before the loop, a start strobe loads two zero-relative counts: the number of remaining iterations and the number of drain stages. The start strobe also resets the stage-enable flags so that only the first stage is enabled.

Once per pass through the loop body, the issuing logic pulses a branch strobe. The branch strobe has two phases:
- While iterations remain, each strobe counts the iteration counter down and shifts a 1 into the stage-enable chain.
- After the iterations are used up, each strobe counts the drain counter down and shifts a 0 into the chain.

Each strobe returns a taken or fall-through answer in the same cycle. Fall-through comes only when both counters are zero, and it ends the loop.

The stage enables come from a small circular flag file. A rotation base register selects the entry that reads as stage 0. Decrementing the base on every taken branch moves each flag up one stage without copying any data. The first `NUM_STAGES` logical flags drive the stage gates. The counters and the rotation base are visible on status outputs.

Top module: `loop_pipe_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no strobe, lc_o, esc_o and rrb_o are zero, stage_en_o is all zero, and active_o and taken_o are low.
- R2: A start_i pulse loads lc_o from lc_init_i and esc_o from esc_init_i, and leaves rrb_o unchanged. In the next cycle, stage_en_o reads with only bit 0 set, and active_o is high.
- R3: A branch_i pulse while active, with lc_o nonzero, has these effects:
  - taken_o is high in the same cycle.
  - In the next cycle, lc_o is one lower, esc_o is unchanged, and stage_en_o bit 0 is 1.
- R4: A branch_i pulse while active, with lc_o zero and esc_o nonzero, has these effects:
  - taken_o is high in the same cycle.
  - In the next cycle, esc_o is one lower, lc_o stays zero, and stage_en_o bit 0 is 0.
- R5: A branch_i pulse while active, with lc_o and esc_o both zero, gives taken_o low (fall-through). The counters stay zero and active_o is low in the next cycle.
- R6: After any taken branch, stage_en_o bit i (for i of 1 or more) equals the value bit i-1 held before the branch.
- R7: A loop loaded with iteration count N-1 and drain count S-1 yields exactly N+S-2 taken branches before its fall-through, so N+S-1 passes in all. After pass j (j = 0 at start), stage_en_o bit i is 1 exactly when 0 <= j-i <= N-1.
- R8: When start_i and branch_i are high in the same cycle, the start wins:
  - taken_o is low in that cycle.
  - The counters are reloaded and rrb_o does not move.
- R9: A branch_i pulse while active_o is low gives taken_o low. It changes none of lc_o, esc_o, rrb_o and stage_en_o.
- R10: Each taken branch lowers rrb_o by one modulo PRED_DEPTH, so 0 wraps to PRED_DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loop entry strobe: load counts and reset stage enables |
| lc_init_i | input | CNT_W | Zero-relative iteration count loaded at start |
| esc_init_i | input | CNT_W | Zero-relative drain stage count loaded at start |
| branch_i | input | 1 | Loop-back strobe, one per kernel pass |
| taken_o | output | 1 | Same-cycle answer to branch_i: 1 loop back, 0 exit |
| active_o | output | 1 | High from start until the fall-through |
| stage_en_o | output | NUM_STAGES | Logical stage enables, bit i gates stage i |
| lc_o | output | CNT_W | Current iteration counter |
| esc_o | output | CNT_W | Current drain counter |
| rrb_o | output | RRB_W | Current rotation base |

## Verification
The assertions that predict a counter step take two things for granted: start_i and branch_i are single-cycle strobes, and the counts driven at start are steady in the cycle start_i is high. The step properties also assume that NUM_STAGES does not exceed PRED_DEPTH, so no two logical stages alias one physical flag. The bench drives every strobe for exactly one clock with the inputs set up half a period ahead. It uses the default depth of eight against four stages, and it runs one loop long enough to take the rotation base around its wrap point.

// File: rtl/loop_pipe_ctrl_pkg.sv
package loop_pipe_ctrl_pkg;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_FILL  = 2'd1,
    STEP_DRAIN = 2'd2,
    STEP_EXIT  = 2'd3
  } step_e;

endpackage

// File: rtl/lpc_counters.sv
module lpc_counters
  import loop_pipe_ctrl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] lc_init_i,
  input  logic [CNT_W-1:0] esc_init_i,
  input  logic             br_i,
  output step_e            step_o,
  output logic [CNT_W-1:0] lc_o,
  output logic [CNT_W-1:0] esc_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lc_q, esc_q;
  step_e            step;

  // phase decision: fill while iterations remain, then drain, then exit
  always_comb begin
    if (!br_i)           step = STEP_NONE;
    else if (lc_q != '0)  step = STEP_FILL;
    else if (esc_q != '0) step = STEP_DRAIN;
    else                  step = STEP_EXIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q  <= '0;
      esc_q <= '0;
    end else if (load_i) begin
      lc_q  <= lc_init_i;
      esc_q <= esc_init_i;
    end else begin
      unique case (step)
        STEP_FILL:  lc_q  <= lc_q - ONE;
        STEP_DRAIN: esc_q <= esc_q - ONE;
        default: ;
      endcase
    end
  end

  assign step_o = step;
  assign lc_o   = lc_q;
  assign esc_o  = esc_q;

endmodule

// File: rtl/lpc_pred_file.sv
module lpc_pred_file #(
  parameter int PRED_DEPTH = 8,
  parameter int NUM_STAGES = 4,
  parameter int RRB_W      = (PRED_DEPTH > 1) ? $clog2(PRED_DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  rotate_i,
  input  logic                  fill_i,
  output logic [RRB_W-1:0]      rrb_o,
  output logic [NUM_STAGES-1:0] stage_en_o
);

  localparam int               IW   = RRB_W + 1;
  localparam logic [IW-1:0]    DEPW = IW'(PRED_DEPTH);
  localparam logic [RRB_W-1:0] TOP  = RRB_W'(PRED_DEPTH - 1);

  logic [PRED_DEPTH-1:0] flags_q;
  logic [RRB_W-1:0]      rrb_q, rrb_nxt;

  assign rrb_nxt = (rrb_q == '0) ? TOP : rrb_q - RRB_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      rrb_q   <= '0;
    end else if (clear_i) begin
      flags_q        <= '0;
      flags_q[rrb_q] <= 1'b1;
    end else if (rotate_i) begin
      rrb_q            <= rrb_nxt;
      flags_q[rrb_nxt] <= fill_i;
    end
  end

  // logical stage i reads physical entry (rrb + i) mod depth
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_map
    logic [IW-1:0] sum, idx;
    assign sum = {1'b0, rrb_q} + IW'(i);
    assign idx = (sum >= DEPW) ? sum - DEPW : sum;
    assign stage_en_o[i] = flags_q[idx[RRB_W-1:0]];
  end

  assign rrb_o = rrb_q;

endmodule

// File: rtl/loop_pipe_ctrl.sv
module loop_pipe_ctrl
  import loop_pipe_ctrl_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRED_DEPTH = 8,
  parameter int NUM_STAGES = 4,
  parameter int RRB_W      = (PRED_DEPTH > 1) ? $clog2(PRED_DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      lc_init_i,
  input  logic [CNT_W-1:0]      esc_init_i,
  input  logic                  branch_i,
  output logic                  taken_o,
  output logic                  active_o,
  output logic [NUM_STAGES-1:0] stage_en_o,
  output logic [CNT_W-1:0]      lc_o,
  output logic [CNT_W-1:0]      esc_o,
  output logic [RRB_W-1:0]      rrb_o
);

  logic  active_q;
  logic  br_q;
  step_e step;

  // start has priority; idle strobes are dropped
  assign br_q = branch_i & active_q & ~start_i;

  lpc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .lc_init_i  (lc_init_i),
    .esc_init_i (esc_init_i),
    .br_i       (br_q),
    .step_o     (step),
    .lc_o       (lc_o),
    .esc_o      (esc_o)
  );

  lpc_pred_file #(
    .PRED_DEPTH (PRED_DEPTH),
    .NUM_STAGES (NUM_STAGES),
    .RRB_W      (RRB_W)
  ) u_pred (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_i),
    .rotate_i   (taken_o),
    .fill_i     (step == STEP_FILL),
    .rrb_o      (rrb_o),
    .stage_en_o (stage_en_o)
  );

  assign taken_o = (step == STEP_FILL) || (step == STEP_DRAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                active_q <= 1'b0;
    else if (start_i)           active_q <= 1'b1;
    else if (step == STEP_EXIT) active_q <= 1'b0;
  end

  assign active_o = active_q;

endmodule

// File: rtl/loop_pipe_ctrl_checker.sv
module loop_pipe_ctrl_checker #(
  parameter int CNT_W      = 16,
  parameter int PRED_DEPTH = 8,
  parameter int NUM_STAGES = 4,
  parameter int RRB_W      = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic [CNT_W-1:0]      lc_init_i,
  input logic [CNT_W-1:0]      esc_init_i,
  input logic                  branch_i,
  input logic                  taken_o,
  input logic                  active_o,
  input logic [NUM_STAGES-1:0] stage_en_o,
  input logic [CNT_W-1:0]      lc_o,
  input logic [CNT_W-1:0]      esc_o,
  input logic [RRB_W-1:0]      rrb_o
);

  localparam logic [CNT_W-1:0]      ONE = CNT_W'(1);
  localparam logic [RRB_W-1:0]      TOP = RRB_W'(PRED_DEPTH - 1);
  localparam logic [NUM_STAGES-1:0] P0  = NUM_STAGES'(1);

  logic live_br;
  assign live_br = active_o && branch_i && !start_i;

  assert_fill_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_br && lc_o != '0) |=> (lc_o == $past(lc_o) - ONE) && (esc_o == $past(esc_o)) && stage_en_o[0]);

  assert_fill_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_br && lc_o != '0) |-> taken_o);

  assert_drain_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_br && lc_o == '0 && esc_o != '0) |=> (esc_o == $past(esc_o) - ONE) && (lc_o == '0) && !stage_en_o[0]);

  assert_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_br && lc_o == '0 && esc_o == '0) |=> !active_o && lc_o == '0 && esc_o == '0);

  assert_exit_answer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_br && lc_o == '0 && esc_o == '0) |-> !taken_o);

  assert_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && !start_i) |=> stage_en_o[NUM_STAGES-1:1] == $past(stage_en_o[NUM_STAGES-2:0]));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o && stage_en_o == P0 && lc_o == $past(lc_init_i)
                && esc_o == $past(esc_init_i) && rrb_o == $past(rrb_o));

  assert_start_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !taken_o);

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> lc_o == $past(lc_o) && esc_o == $past(esc_o)
                              && rrb_o == $past(rrb_o) && stage_en_o == $past(stage_en_o));

  assert_idle_answer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !taken_o);

  assert_rrb_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && rrb_o == '0) |=> rrb_o == TOP);

endmodule

bind loop_pipe_ctrl loop_pipe_ctrl_checker #(
  .CNT_W      (CNT_W),
  .PRED_DEPTH (PRED_DEPTH),
  .NUM_STAGES (NUM_STAGES),
  .RRB_W      (RRB_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .lc_init_i  (lc_init_i),
  .esc_init_i (esc_init_i),
  .branch_i   (branch_i),
  .taken_o    (taken_o),
  .active_o   (active_o),
  .stage_en_o (stage_en_o),
  .lc_o       (lc_o),
  .esc_o      (esc_o),
  .rrb_o      (rrb_o)
);

// File: tb/loop_pipe_ctrl_tb.sv
module loop_pipe_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PRED_DEPTH = 8;
  localparam int NUM_STAGES = 4;
  localparam int RRB_W      = 3;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  start_i = 1'b0;
  logic [CNT_W-1:0]      lc_init_i = '0;
  logic [CNT_W-1:0]      esc_init_i = '0;
  logic                  branch_i = 1'b0;
  logic                  taken_o, active_o;
  logic [NUM_STAGES-1:0] stage_en_o;
  logic [CNT_W-1:0]      lc_o, esc_o;
  logic [RRB_W-1:0]      rrb_o;

  int checks = 0;
  int errors = 0;
  int exp_rrb = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  loop_pipe_ctrl #(
    .CNT_W(CNT_W), .PRED_DEPTH(PRED_DEPTH), .NUM_STAGES(NUM_STAGES), .RRB_W(RRB_W)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .lc_init_i(lc_init_i),
    .esc_init_i(esc_init_i), .branch_i(branch_i), .taken_o(taken_o),
    .active_o(active_o), .stage_en_o(stage_en_o), .lc_o(lc_o), .esc_o(esc_o),
    .rrb_o(rrb_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NUM_STAGES-1:0] exp_vec(input int pass, input int lc0);
    logic [NUM_STAGES-1:0] v;
    for (int i = 0; i < NUM_STAGES; i++) v[i] = (pass - i >= 0) && (pass - i <= lc0);
    return v;
  endfunction

  task automatic do_start(input int lc0, input int esc0, input bit with_br, output bit tk);
    @(negedge clk_i);
    start_i = 1'b1; lc_init_i = CNT_W'(lc0); esc_init_i = CNT_W'(esc0); branch_i = with_br;
    #1 tk = taken_o;
    @(negedge clk_i);
    start_i = 1'b0; branch_i = 1'b0;
    #1;
  endtask

  task automatic do_branch(output bit tk);
    @(negedge clk_i);
    branch_i = 1'b1;
    #1 tk = taken_o;
    @(negedge clk_i);
    branch_i = 1'b0;
    #1;
  endtask

  // full loop; checks every pass against the closed-form enable pattern
  task automatic t_loop(input int lc0, input int esc0);
    bit tk;
    int taken_cnt = 0;
    do_start(lc0, esc0, 1'b0, tk);
    chk(lc_o == CNT_W'(lc0) && esc_o == CNT_W'(esc0), "R2 counts loaded", lc_o, lc0);
    chk(stage_en_o == NUM_STAGES'(1) && active_o, "R2 stage0 only", stage_en_o, 1);
    chk(rrb_o == RRB_W'(exp_rrb), "R2 rrb kept", rrb_o, exp_rrb);
    for (int j = 1; j <= lc0 + esc0; j++) begin
      automatic logic [NUM_STAGES-1:0] prev = stage_en_o;
      automatic bit fill = (j <= lc0);
      do_branch(tk);
      if (tk) taken_cnt++;
      exp_rrb = (exp_rrb + PRED_DEPTH - 1) % PRED_DEPTH;
      chk(tk, fill ? "R3 taken" : "R4 taken", tk, 1);
      if (fill) chk(lc_o == CNT_W'(lc0 - j) && stage_en_o[0], "R3 lc step", lc_o, lc0 - j);
      else chk(esc_o == CNT_W'(esc0 - (j - lc0)) && lc_o == '0 && !stage_en_o[0],
               "R4 esc step", esc_o, esc0 - (j - lc0));
      chk(stage_en_o[NUM_STAGES-1:1] == prev[NUM_STAGES-2:0], "R6 shift",
          stage_en_o, {prev[NUM_STAGES-2:0], stage_en_o[0]});
      chk(stage_en_o == exp_vec(j, lc0), "R7 pattern", stage_en_o, exp_vec(j, lc0));
      chk(rrb_o == RRB_W'(exp_rrb), "R10 rrb", rrb_o, exp_rrb);
    end
    do_branch(tk);
    chk(!tk, "R5 fall-through", tk, 0);
    chk(!active_o && lc_o == '0 && esc_o == '0, "R5 exit state", active_o, 0);
    chk(taken_cnt == lc0 + esc0, "R7 pass count", taken_cnt, lc0 + esc0);
  endtask

  task automatic t_reset();
    chk(lc_o == '0 && esc_o == '0 && rrb_o == '0, "R1 counters", lc_o + esc_o + rrb_o, 0);
    chk(stage_en_o == '0 && !active_o && !taken_o, "R1 flags", stage_en_o, 0);
  endtask

  task automatic t_idle_branch();
    bit tk;
    logic [NUM_STAGES-1:0] v = stage_en_o;
    logic [RRB_W-1:0] r = rrb_o;
    do_branch(tk);
    chk(!tk, "R9 idle answer", tk, 0);
    chk(stage_en_o == v && rrb_o == r && lc_o == '0 && esc_o == '0, "R9 idle state",
        rrb_o, r);
  endtask

  task automatic t_collision();
    bit tk;
    do_start(5, 2, 1'b0, tk);
    do_branch(tk);
    exp_rrb = (exp_rrb + PRED_DEPTH - 1) % PRED_DEPTH;
    do_start(2, 1, 1'b1, tk);
    chk(!tk, "R8 no taken", tk, 0);
    chk(lc_o == CNT_W'(2) && esc_o == CNT_W'(1), "R8 reload", lc_o, 2);
    chk(rrb_o == RRB_W'(exp_rrb) && stage_en_o == NUM_STAGES'(1), "R8 rrb still", rrb_o, exp_rrb);
    for (int j = 0; j < 3; j++) begin
      do_branch(tk);
      exp_rrb = (exp_rrb + PRED_DEPTH - 1) % PRED_DEPTH;
    end
    do_branch(tk);
    chk(!tk && !active_o, "R8 loop ends normally", tk, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 chk(lc_o == '0 && !active_o && stage_en_o == '0, "R1 in reset", lc_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    t_reset();
    t_idle_branch();
    t_loop(3, 3);
    t_loop(0, 0);
    t_loop(2, 0);
    t_loop(0, 3);
    t_idle_branch();
    t_collision();
    t_loop(9, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule